// File: doc/BRIEF.md
# DMA Channel Register and Interrupt Front End

This block is the register-side front end of a multi-channel descriptor DMA controller. A 32-bit word bus reaches one bank of control registers per channel. Each bank holds descriptor pointers, a configuration word, a command word and a stream-command word, plus interrupt mask, raw and masked interrupt state. The bank also keeps a small run/stop/reset state for its channel. The block moves no data and fetches no descriptors. It turns register writes into one-cycle request pulses for a separate channel engine: start, continue, load data descriptor and load context.

The engine reports back three things: an end-of-list flag, a stream-command source field, and interrupt events. Events are collected in the raw interrupt word and filtered by the mask. Each channel drives one interrupt line, which is high while any unmasked event is pending. Software clears pending events by writing their bits to an acknowledge register, which always reads as zero.

Top module: `dmafe_top`

## Requirements
- R1: The channel index is the address bits from bit 13 upward, and the register index is address bits [7:2]. A write to one channel leaves every other channel's registers, pulses and interrupt line untouched.
- R2: After reset every register reads zero, except the status word, which reads 0x101 (state 1, source 1).
- R3: These registers store the full word written and read it back: the pointers at byte offsets 0x00, 0x58, 0x5C, 0x60 and 0x7C, configuration at 0x84 and command at 0x80. The mask at 0x8C keeps only its low IRQ_W bits. Read data and bus_rvalid appear one cycle after bus_rd.
- R4: The state is one-hot (reset 1, stopped 2, running 4). A configuration write with bit 0 clear forces reset. A write with bit 0 set and bit 1 set forces stopped. A write with bit 0 set and bit 1 clear keeps the current state.
- R5: The status word at 0x88 carries the state in bits [2:0], the engine's end-of-list flag in bit 5 and the engine's source field in bits [9:8]. The engine inputs are registered once before they appear in the status word.
- R6: The stream command at 0x9C stores only bits [9:0]. Bit 6 gives a load-data pulse and bit 9 a load-context pulse. Bit 6 together with bit 5 gives a start pulse and moves the state to running, but only while configuration bit 0 is set and bit 1 is clear. All pulses appear one cycle after the write.
- R7: A write to the command register gives a continue pulse one cycle later, only while enabled, not stopped and running. Any set bit other than bit 0 gives a one-cycle illegal-command pulse.
- R8: Engine interrupt events set raw bits (0x94), which stay set until acknowledged. Writing 0x90 clears the raw bits given in the value. An event in the same cycle as its acknowledge wins. 0x90 reads zero.
- R9: The masked word at 0x98 equals raw AND mask, and the channel interrupt line is high exactly when it is nonzero. Both follow any raw or mask change after one cycle.
- R10: An access with bus_be other than 4'b1111 raises bus_err for one cycle, one cycle later. Such a write changes nothing, and such a read returns zero.
- R11: Writes to status, raw, masked and unlisted offsets are ignored, and unlisted offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_be | input | 4 | Byte enables, must be all ones |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid |
| bus_err | output | 1 | Partial-word access flag |
| eng_eol | input | NUM_CH | End-of-list flag per channel |
| eng_src | input | NUM_CH*SRC_W | Stream-command source per channel |
| eng_irq_set | input | NUM_CH*IRQ_W | Interrupt events per channel |
| ch_irq | output | NUM_CH | Interrupt line per channel |
| ch_start | output | NUM_CH | Start pulse |
| ch_continue | output | NUM_CH | Continue pulse |
| ch_load_data | output | NUM_CH | Load-data-descriptor pulse |
| ch_load_ctx | output | NUM_CH | Load-context pulse |
| ch_cmd_bad | output | NUM_CH | Illegal-command pulse |
| ch_state | output | NUM_CH*3 | One-hot channel state |

## Verification
A wrong channel state shows on ch_state at the edge after the write that caused it. It also shows later, when a command write fails to produce its continue pulse, or a stream start is wrongly granted. A lost or stuck raw interrupt bit shows on ch_irq one cycle after the event or the acknowledge. It is also visible in the raw and masked words on the next read. Decode faults show on the very next read of the other channel, or of the same offset, as a wrong or missing value.

// File: rtl/dmafe_pkg.sv
package dmafe_pkg;
  localparam int IDX_W = 6;
  localparam int WIN_LSB = 13;

  typedef enum logic [2:0] {
    ST_RST  = 3'd1,
    ST_STOP = 3'd2,
    ST_RUN  = 3'd4
  } ch_state_e;

  // word indices within a channel window (byte offset / 4)
  localparam logic [IDX_W-1:0] IX_DATA = 6'h00;
  localparam logic [IDX_W-1:0] IX_SAVE = 6'h16;
  localparam logic [IDX_W-1:0] IX_SBUF = 6'h17;
  localparam logic [IDX_W-1:0] IX_GRP  = 6'h18;
  localparam logic [IDX_W-1:0] IX_GDN  = 6'h1F;
  localparam logic [IDX_W-1:0] IX_CMD  = 6'h20;
  localparam logic [IDX_W-1:0] IX_CFG  = 6'h21;
  localparam logic [IDX_W-1:0] IX_STAT = 6'h22;
  localparam logic [IDX_W-1:0] IX_MASK = 6'h23;
  localparam logic [IDX_W-1:0] IX_ACK  = 6'h24;
  localparam logic [IDX_W-1:0] IX_RAW  = 6'h25;
  localparam logic [IDX_W-1:0] IX_MSKD = 6'h26;
  localparam logic [IDX_W-1:0] IX_SCMD = 6'h27;

  localparam int CFG_EN   = 0;
  localparam int CFG_STOP = 1;
  localparam int SC_W     = 10;
  localparam int SC_BURST = 5;
  localparam int SC_LDATA = 6;
  localparam int SC_LCTX  = 9;
  localparam int ST_EOL   = 5;
  localparam int ST_SRC   = 8;
endpackage

// File: rtl/dmafe_decode.sv
module dmafe_decode #(
  parameter int NUM_CH  = 2,
  parameter int CH_BITS = 1,
  parameter int ADDR_W  = 14
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   wr,
  input  logic                   rd,
  input  logic [3:0]             be,
  output logic [NUM_CH-1:0]      wr_sel,
  output logic [CH_BITS-1:0]     ch_idx,
  output logic                   rd_hit,
  output logic [dmafe_pkg::IDX_W-1:0] reg_idx,
  output logic                   err_q
);
  import dmafe_pkg::*;

  logic full;
  logic in_range;

  assign full     = (be == 4'b1111);
  assign ch_idx   = addr[ADDR_W-1:WIN_LSB];
  assign in_range = (32'(ch_idx) < NUM_CH);
  assign reg_idx  = addr[IDX_W+1:2];
  assign rd_hit   = full && in_range;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
    assign wr_sel[g] = wr && full && in_range && (ch_idx == CH_BITS'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= (wr || rd) && !full;
  end

  p_err_cause_r10: assert property (@(posedge clk) disable iff (rst)
    err_q |-> $past((wr || rd) && (be != 4'b1111)));
  p_sel_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_sel));
endmodule

// File: rtl/dmafe_irq.sv
module dmafe_irq #(
  parameter int IRQ_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IRQ_W-1:0] set,
  input  logic             mask_we,
  input  logic             ack_we,
  input  logic [IRQ_W-1:0] wval,
  output logic [IRQ_W-1:0] raw_q,
  output logic [IRQ_W-1:0] mask_q,
  output logic [IRQ_W-1:0] masked_q,
  output logic             irq_q
);
  logic [IRQ_W-1:0] ack_bits;
  logic [IRQ_W-1:0] raw_n;
  logic [IRQ_W-1:0] mask_n;

  always_comb begin
    ack_bits = ack_we ? wval : '0;
    raw_n    = (raw_q & ~ack_bits) | set;
    mask_n   = mask_we ? wval : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q    <= '0;
      mask_q   <= '0;
      masked_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      raw_q    <= raw_n;
      mask_q   <= mask_n;
      masked_q <= raw_n & mask_n;
      irq_q    <= |(raw_n & mask_n);
    end
  end

  p_ack_clear_r8: assert property (@(posedge clk) disable iff (rst)
    ack_we |=> ((raw_q & $past(wval & ~set)) == '0));
  p_set_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (|set) |=> ((raw_q & $past(set)) == $past(set)));
  p_irq_mask_r9: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> ((masked_q & mask_q & raw_q) != '0));
  p_irq_low_r9: assert property (@(posedge clk) disable iff (rst)
    (masked_q == '0) |-> !irq_q);
endmodule

// File: rtl/dmafe_channel.sv
module dmafe_channel #(
  parameter int IRQ_W = 4,
  parameter int SRC_W = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic [dmafe_pkg::IDX_W-1:0] idx,
  input  logic [31:0]                 wdata,
  input  logic                        eng_eol,
  input  logic [SRC_W-1:0]            eng_src,
  input  logic [IRQ_W-1:0]            irq_set,
  output logic [31:0]                 rd_word,
  output logic                        irq,
  output logic                        start_p,
  output logic                        cont_p,
  output logic                        ldata_p,
  output logic                        lctx_p,
  output logic                        cmd_bad_p,
  output logic [2:0]                  state
);
  import dmafe_pkg::*;

  logic [31:0]      data_q, save_q, sbuf_q, grp_q, gdn_q, cmd_q, cfg_q;
  logic [SC_W-1:0]  scmd_q;
  logic             eol_q;
  logic [SRC_W-1:0] src_q;
  ch_state_e        state_q;
  logic [IRQ_W-1:0] raw, mask, masked;

  logic cfg_we, cmd_we, scmd_we, mask_we, ack_we;
  logic may_run, start_req;

  assign cfg_we    = we && (idx == IX_CFG);
  assign cmd_we    = we && (idx == IX_CMD);
  assign scmd_we   = we && (idx == IX_SCMD);
  assign mask_we   = we && (idx == IX_MASK);
  assign ack_we    = we && (idx == IX_ACK);
  assign may_run   = cfg_q[CFG_EN] && !cfg_q[CFG_STOP];
  assign start_req = scmd_we && wdata[SC_LDATA] && wdata[SC_BURST] && may_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0; save_q <= '0; sbuf_q <= '0; grp_q <= '0;
      gdn_q  <= '0; cmd_q  <= '0; cfg_q  <= '0; scmd_q <= '0;
    end else if (we) begin
      case (idx)
        IX_DATA: data_q <= wdata;
        IX_SAVE: save_q <= wdata;
        IX_SBUF: sbuf_q <= wdata;
        IX_GRP:  grp_q  <= wdata;
        IX_GDN:  gdn_q  <= wdata;
        IX_CMD:  cmd_q  <= wdata;
        IX_CFG:  cfg_q  <= wdata;
        IX_SCMD: scmd_q <= wdata[SC_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RST;
    end else if (cfg_we) begin
      if (!wdata[CFG_EN])        state_q <= ST_RST;
      else if (wdata[CFG_STOP])  state_q <= ST_STOP;
    end else if (start_req) begin
      state_q <= ST_RUN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eol_q     <= 1'b0;
      src_q     <= SRC_W'(1);
      start_p   <= 1'b0;
      cont_p    <= 1'b0;
      ldata_p   <= 1'b0;
      lctx_p    <= 1'b0;
      cmd_bad_p <= 1'b0;
    end else begin
      eol_q     <= eng_eol;
      src_q     <= eng_src;
      start_p   <= start_req;
      cont_p    <= cmd_we && may_run && (state_q == ST_RUN);
      ldata_p   <= scmd_we && wdata[SC_LDATA];
      lctx_p    <= scmd_we && wdata[SC_LCTX];
      cmd_bad_p <= cmd_we && (|wdata[31:1]);
    end
  end

  dmafe_irq #(.IRQ_W(IRQ_W)) i_irq (
    .clk      (clk),
    .rst      (rst),
    .set      (irq_set),
    .mask_we  (mask_we),
    .ack_we   (ack_we),
    .wval     (wdata[IRQ_W-1:0]),
    .raw_q    (raw),
    .mask_q   (mask),
    .masked_q (masked),
    .irq_q    (irq)
  );

  always_comb begin
    rd_word = '0;
    case (idx)
      IX_DATA: rd_word = data_q;
      IX_SAVE: rd_word = save_q;
      IX_SBUF: rd_word = sbuf_q;
      IX_GRP:  rd_word = grp_q;
      IX_GDN:  rd_word = gdn_q;
      IX_CMD:  rd_word = cmd_q;
      IX_CFG:  rd_word = cfg_q;
      IX_STAT: begin
        rd_word[2:0]              = state_q;
        rd_word[ST_EOL]           = eol_q;
        rd_word[ST_SRC +: SRC_W]  = src_q;
      end
      IX_MASK: rd_word[IRQ_W-1:0] = mask;
      IX_RAW:  rd_word[IRQ_W-1:0] = raw;
      IX_MSKD: rd_word[IRQ_W-1:0] = masked;
      IX_SCMD: rd_word[SC_W-1:0]  = scmd_q;
      default: rd_word = '0;
    endcase
  end

  assign state = state_q;

  p_state_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $countones(state_q) == 1);
  p_cfg_reset_r4: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !wdata[CFG_EN]) |=> (state_q == ST_RST));
  p_cont_gate_r7: assert property (@(posedge clk) disable iff (rst)
    cont_p |-> ($past(state_q) == ST_RUN));
  p_start_run_r6: assert property (@(posedge clk) disable iff (rst)
    start_p |-> (state_q == ST_RUN));
  p_start_data_r6: assert property (@(posedge clk) disable iff (rst)
    start_p |-> ldata_p);
endmodule

// File: rtl/dmafe_top.sv
module dmafe_top #(
  parameter int NUM_CH  = 2,
  parameter int IRQ_W   = 4,
  parameter int SRC_W   = 2,
  parameter int CH_BITS = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  parameter int ADDR_W  = dmafe_pkg::WIN_LSB + CH_BITS
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [3:0]                bus_be,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  output logic                      bus_rvalid,
  output logic                      bus_err,
  input  logic [NUM_CH-1:0]         eng_eol,
  input  logic [NUM_CH*SRC_W-1:0]   eng_src,
  input  logic [NUM_CH*IRQ_W-1:0]   eng_irq_set,
  output logic [NUM_CH-1:0]         ch_irq,
  output logic [NUM_CH-1:0]         ch_start,
  output logic [NUM_CH-1:0]         ch_continue,
  output logic [NUM_CH-1:0]         ch_load_data,
  output logic [NUM_CH-1:0]         ch_load_ctx,
  output logic [NUM_CH-1:0]         ch_cmd_bad,
  output logic [NUM_CH*3-1:0]       ch_state
);
  import dmafe_pkg::*;

  logic [NUM_CH-1:0]  wr_sel;
  logic [CH_BITS-1:0] ch_idx;
  logic               rd_hit;
  logic [IDX_W-1:0]   reg_idx;
  logic [31:0]        words [NUM_CH];

  dmafe_decode #(.NUM_CH(NUM_CH), .CH_BITS(CH_BITS), .ADDR_W(ADDR_W)) i_dec (
    .clk     (clk),
    .rst     (rst),
    .addr    (bus_addr),
    .wr      (bus_wr),
    .rd      (bus_rd),
    .be      (bus_be),
    .wr_sel  (wr_sel),
    .ch_idx  (ch_idx),
    .rd_hit  (rd_hit),
    .reg_idx (reg_idx),
    .err_q   (bus_err)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dmafe_channel #(.IRQ_W(IRQ_W), .SRC_W(SRC_W)) i_ch (
      .clk       (clk),
      .rst       (rst),
      .we        (wr_sel[g]),
      .idx       (reg_idx),
      .wdata     (bus_wdata),
      .eng_eol   (eng_eol[g]),
      .eng_src   (eng_src[g*SRC_W +: SRC_W]),
      .irq_set   (eng_irq_set[g*IRQ_W +: IRQ_W]),
      .rd_word   (words[g]),
      .irq       (ch_irq[g]),
      .start_p   (ch_start[g]),
      .cont_p    (ch_continue[g]),
      .ldata_p   (ch_load_data[g]),
      .lctx_p    (ch_load_ctx[g]),
      .cmd_bad_p (ch_cmd_bad[g]),
      .state     (ch_state[g*3 +: 3])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      bus_rdata  <= (bus_rd && rd_hit) ? words[ch_idx] : '0;
    end
  end

  p_rvalid_r3: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> $past(bus_rd));
  p_bad_read_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && bus_err) |-> (bus_rdata == '0));
endmodule

// File: tb/test_dmafe_top.sv
module test_dmafe_top;
  localparam int NUM_CH = 2;
  localparam int IRQ_W  = 4;
  localparam int SRC_W  = 2;
  localparam int ADDR_W = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_be = 4'hF;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid, bus_err;
  logic [NUM_CH-1:0] eng_eol = '0;
  logic [NUM_CH*SRC_W-1:0] eng_src = {2'b01, 2'b01};
  logic [NUM_CH*IRQ_W-1:0] eng_irq_set = '0;
  logic [NUM_CH-1:0] ch_irq, ch_start, ch_continue, ch_load_data, ch_load_ctx, ch_cmd_bad;
  logic [NUM_CH*3-1:0] ch_state;

  int nchk = 0;
  int nbad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dmafe_top #(.NUM_CH(NUM_CH), .IRQ_W(IRQ_W), .SRC_W(SRC_W)) i_dmafe_top (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .bus_err(bus_err), .eng_eol(eng_eol),
    .eng_src(eng_src), .eng_irq_set(eng_irq_set), .ch_irq(ch_irq),
    .ch_start(ch_start), .ch_continue(ch_continue), .ch_load_data(ch_load_data),
    .ch_load_ctx(ch_load_ctx), .ch_cmd_bad(ch_cmd_bad), .ch_state(ch_state)
  );

  typedef struct packed {
    logic        wr;
    logic        ch;
    logic [7:0]  off;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 8'h88, 32'h0,        32'h00000101, 8'd2},  // R2 status reset ch0
    '{1'b0, 1'b1, 8'h88, 32'h0,        32'h00000101, 8'd2},  // R2 status reset ch1
    '{1'b0, 1'b0, 8'h58, 32'h0,        32'h0,        8'd2},  // R2
    '{1'b0, 1'b1, 8'h9C, 32'h0,        32'h0,        8'd2},  // R2
    '{1'b1, 1'b0, 8'h58, 32'hA5A50010, 32'h0,        8'd1},
    '{1'b1, 1'b1, 8'h58, 32'h12340020, 32'h0,        8'd1},
    '{1'b0, 1'b0, 8'h58, 32'h0,        32'hA5A50010, 8'd1},  // R1 channel separation
    '{1'b0, 1'b1, 8'h58, 32'h0,        32'h12340020, 8'd1},  // R1
    '{1'b1, 1'b0, 8'h00, 32'h00001000, 32'h0,        8'd3},
    '{1'b0, 1'b0, 8'h00, 32'h0,        32'h00001000, 8'd3},  // R3
    '{1'b1, 1'b0, 8'h5C, 32'hDEAD0004, 32'h0,        8'd3},
    '{1'b0, 1'b0, 8'h5C, 32'h0,        32'hDEAD0004, 8'd3},  // R3
    '{1'b1, 1'b0, 8'h60, 32'h00C0FFEE, 32'h0,        8'd3},
    '{1'b1, 1'b0, 8'h7C, 32'h0BAD0000, 32'h0,        8'd3},
    '{1'b0, 1'b0, 8'h60, 32'h0,        32'h00C0FFEE, 8'd3},  // R3
    '{1'b0, 1'b0, 8'h7C, 32'h0,        32'h0BAD0000, 8'd3},  // R3
    '{1'b1, 1'b0, 8'h8C, 32'hFFFFFFFF, 32'h0,        8'd3},
    '{1'b0, 1'b0, 8'h8C, 32'h0,        32'h0000000F, 8'd3},  // R3 mask width
    '{1'b1, 1'b0, 8'h8C, 32'h0,        32'h0,        8'd3},
    '{1'b1, 1'b0, 8'h88, 32'hFFFFFFFF, 32'h0,        8'd11},
    '{1'b0, 1'b0, 8'h88, 32'h0,        32'h00000101, 8'd11}, // R11 status read-only
    '{1'b1, 1'b0, 8'h40, 32'h00000055, 32'h0,        8'd11},
    '{1'b0, 1'b0, 8'h40, 32'h0,        32'h0,        8'd11}, // R11 unlisted
    '{1'b1, 1'b0, 8'h9C, 32'hFFFFFC00, 32'h0,        8'd6},
    '{1'b0, 1'b0, 8'h9C, 32'h0,        32'h0,        8'd6},  // R6 upper bits dropped
    '{1'b1, 1'b0, 8'h94, 32'h0000000F, 32'h0,        8'd11},
    '{1'b0, 1'b0, 8'h94, 32'h0,        32'h0,        8'd11}, // R11 raw read-only
    '{1'b0, 1'b0, 8'h98, 32'h0,        32'h0,        8'd11}, // R11 masked read-only
    '{1'b0, 1'b0, 8'h90, 32'h0,        32'h0,        8'd8}   // R8 ack reads zero
  };

  function automatic logic [ADDR_W-1:0] adr(input int ch, input logic [7:0] off);
    return ADDR_W'((ch << 13) | int'(off));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int ch, input logic [7:0] off, input logic [31:0] d,
                    input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_addr = adr(ch, off); bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 4'hF;
  endtask

  task automatic rd(input int ch, input logic [7:0] off, output logic [31:0] d,
                    input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_addr = adr(ch, off); bus_be = be; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; bus_be = 4'hF;
    d = bus_rvalid ? bus_rdata : 32'hBADBADBA;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R2 irq idle", {30'b0, ch_irq}, 32'h0);
    chk("R2 state reset", {26'b0, ch_state}, {26'b0, 3'd1, 3'd1});

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) wr(int'(VEC[i].ch), VEC[i].off, VEC[i].data);
      else begin
        rd(int'(VEC[i].ch), VEC[i].off, v);
        chk($sformatf("R%0d vec %0d", VEC[i].rq, i), v, VEC[i].exp);
      end
    end

    // R10 partial-word accesses
    wr(0, 8'h00, 32'h0000FFFF, 4'h3);
    chk("R10 err after write", {31'b0, bus_err}, 32'h1);
    rd(0, 8'h00, v);
    chk("R10 write ignored", v, 32'h00001000);
    rd(0, 8'h00, v, 4'hE);
    chk("R10 read zero", v, 32'h0);
    chk("R10 err after read", {31'b0, bus_err}, 32'h1);

    // R4 R6 start from enabled state
    wr(0, 8'h84, 32'h1);
    chk("R4 enable keeps reset", {29'b0, ch_state[2:0]}, 32'h1);
    wr(0, 8'h9C, 32'h60);
    chk("R6 start pulse", {30'b0, ch_start}, 32'h1);
    chk("R6 load data pulse", {30'b0, ch_load_data}, 32'h1);
    chk("R6 no ctx pulse", {30'b0, ch_load_ctx}, 32'h0);
    chk("R6 running", {29'b0, ch_state[2:0]}, 32'h4);
    chk("R1 ch1 untouched", {29'b0, ch_state[5:3]}, 32'h1);
    @(negedge clk);
    chk("R6 pulse one cycle", {30'b0, ch_start}, 32'h0);

    // R7 continue and illegal bits
    wr(0, 8'h80, 32'h1);
    chk("R7 continue", {30'b0, ch_continue}, 32'h1);
    chk("R7 legal cmd", {30'b0, ch_cmd_bad}, 32'h0);
    wr(0, 8'h80, 32'h3);
    chk("R7 illegal flagged", {30'b0, ch_cmd_bad}, 32'h1);
    rd(0, 8'h80, v);
    chk("R3 cmd stored", v, 32'h3);

    // R4 stop and reset priority
    wr(0, 8'h84, 32'h3);
    rd(0, 8'h88, v);
    chk("R4 stopped status", v, 32'h102);
    wr(0, 8'h80, 32'h1);
    chk("R7 no continue when stopped", {30'b0, ch_continue}, 32'h0);
    wr(0, 8'h9C, 32'h260);
    chk("R6 start refused", {30'b0, ch_start}, 32'h0);
    chk("R6 ctx pulse", {30'b0, ch_load_ctx}, 32'h1);
    chk("R6 stays stopped", {29'b0, ch_state[2:0]}, 32'h2);
    wr(0, 8'h84, 32'h2);
    chk("R4 reset wins", {29'b0, ch_state[2:0]}, 32'h1);

    // R5 status fields from engine
    @(negedge clk);
    eng_eol[0] = 1'b1; eng_src[1:0] = 2'b10;
    rd(0, 8'h88, v);
    chk("R5 status pack", v, 32'h221);

    // R8 R9 interrupts on ch1
    wr(1, 8'h8C, 32'h5);
    @(negedge clk);
    eng_irq_set[7:4] = 4'h3;
    @(negedge clk);
    eng_irq_set[7:4] = 4'h0;
    chk("R9 irq raised", {30'b0, ch_irq}, 32'h2);
    rd(1, 8'h94, v);
    chk("R8 raw", v, 32'h3);
    rd(1, 8'h98, v);
    chk("R9 masked", v, 32'h1);
    wr(1, 8'h90, 32'h1);
    chk("R9 irq cleared", {30'b0, ch_irq}, 32'h0);
    rd(1, 8'h94, v);
    chk("R8 ack clears", v, 32'h2);
    @(negedge clk);
    bus_addr = adr(1, 8'h90); bus_wdata = 32'h1; bus_wr = 1'b1;
    eng_irq_set[7:4] = 4'h1;
    @(negedge clk);
    bus_wr = 1'b0; eng_irq_set[7:4] = 4'h0;
    chk("R8 set wins over ack", {30'b0, ch_irq}, 32'h2);
    rd(1, 8'h94, v);
    chk("R8 raw after race", v, 32'h3);
    wr(1, 8'h8C, 32'h0);
    chk("R9 mask off", {30'b0, ch_irq}, 32'h0);

    summary();
  end
endmodule